// File: doc/BRIEF.md
# Two-Way Mailbox Pair with Interrupt Request

This block holds two 32-bit message registers that a host CPU and a DSP share. One register carries messages toward the DSP, the other carries messages toward the CPU. Both sides reach either register through a 16-bit access port that selects one mailbox and one half. The top bit of each mailbox is a pending flag. It changes only as a side effect of accesses. Writing the upper half clears it, so a message that is still being built never looks ready. Writing the lower half sets it, which commits the message. Reading the lower half clears it, which acknowledges the message.

A sender writes the upper half first and the lower half last. The receiver polls the pending output, or takes an interrupt from it. It reads the upper half, then the lower half. Both full words are also visible on side-effect-free peek outputs. When both ports write the same mailbox in one cycle, port A (the host side) wins.

A separate interrupt-request register turns a write with bit 0 set into a one-cycle pulse toward the host. A non-zero write with bit 0 clear is flagged on a warning pulse. The access ports are plain single-cycle strobes with no back-pressure: every access completes in the cycle it is presented. Read data is combinational from the current register contents.

Top module: `mbox_pair_top`

## Requirements
- R1: After reset both mailboxes read as zero, both pending outputs are low, and host_irq and irq_warn are low.
- R2: A write with half select 1 (upper) replaces bits 31:16 with the written data and forces bit 31 to 0, leaving bits 15:0 unchanged.
- R3: A write with half select 0 (lower) replaces bits 15:0 and sets bit 31 to 1, leaving bits 30:16 unchanged.
- R4: A read with half select 0 returns bits 15:0 in the same cycle and clears bit 31 at the next clock edge.
- R5: A read with half select 1 returns bits 31:16, including the pending flag, and leaves the mailbox unchanged.
- R6: peek_to_dsp (box select 0) and peek_to_cpu (box select 1) always show the full 32-bit mailbox contents. pend_to_dsp and pend_to_cpu equal bit 31 of the respective mailbox.
- R7: When a write and a lower-half read hit the same mailbox in one cycle, the write takes effect and the flag follows the written half (set for a lower-half write).
- R8: When both ports write the same mailbox in one cycle, only port A's write takes effect and port B's is discarded.
- R9: An interrupt-request write with bit 0 set produces host_irq high for exactly one cycle, starting at the next clock edge.
- R10: An interrupt-request write of zero produces neither host_irq nor irq_warn.
- R11: An interrupt-request write that is non-zero with bit 0 clear produces a one-cycle irq_warn pulse and no host_irq.
- R12: When the two ports write different mailboxes in one cycle, both writes take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_en | input | 1 | Port A (host side) access strobe |
| a_wr | input | 1 | Port A: 1 = write, 0 = read |
| a_box | input | 1 | Port A mailbox select: 0 = toward DSP, 1 = toward CPU |
| a_hi | input | 1 | Port A half select: 1 = bits 31:16, 0 = bits 15:0 |
| a_wdata | input | HW | Port A write data |
| a_rdata | output | HW | Port A read data (combinational) |
| b_en | input | 1 | Port B (DSP side) access strobe |
| b_wr | input | 1 | Port B: 1 = write, 0 = read |
| b_box | input | 1 | Port B mailbox select, same encoding as a_box |
| b_hi | input | 1 | Port B half select, same encoding as a_hi |
| b_wdata | input | HW | Port B write data |
| b_rdata | output | HW | Port B read data (combinational) |
| irq_wr | input | 1 | Interrupt-request register write strobe |
| irq_wdata | input | HW | Interrupt-request write value |
| host_irq | output | 1 | One-cycle interrupt pulse toward the host |
| irq_warn | output | 1 | One-cycle pulse for an unrecognised request value |
| pend_to_dsp | output | 1 | Pending flag of the mailbox toward the DSP |
| pend_to_cpu | output | 1 | Pending flag of the mailbox toward the CPU |
| peek_to_dsp | output | 2*HW | Full contents of the mailbox toward the DSP |
| peek_to_cpu | output | 2*HW | Full contents of the mailbox toward the CPU |

## Verification
The bench builds the block with the default half width of 16, so each mailbox is a full 32-bit word and the flag sits at bit 31. At that width, an all-ones upper-half write shows the forced-zero flag directly (0x7FFF in the upper half). Reads of the upper half then show the flag returning as 0xFFFF once the lower half is committed. Same-cycle collisions are driven deliberately: port A against port B on one mailbox, on both mailboxes, and a write against an acknowledging read. These cover the priority rules. Interrupt-request values 0x0000, 0x0001, 0x0002, 0x8000 and 0xFFFF cover the pulse, no-op and warning cases.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Mailbox selector encoding shared by both access ports.
  typedef enum logic {
    BOX_TO_DSP = 1'b0,
    BOX_TO_CPU = 1'b1
  } box_e;

  localparam int NBOX = 2;

  // Half selector encoding.
  localparam logic HALF_LO = 1'b0;
  localparam logic HALF_HI = 1'b1;

endpackage

// File: rtl/mbox_arb.sv
// Per-mailbox access resolution: picks the winning writer (port A first)
// and detects a lower-half read that acknowledges the message.
module mbox_arb #(
  parameter int HW   = 16,
  parameter int IDX  = 0
) (
  input  logic          a_en,
  input  logic          a_wr,
  input  logic          a_box,
  input  logic          a_hi,
  input  logic [HW-1:0] a_wdata,
  input  logic          b_en,
  input  logic          b_wr,
  input  logic          b_box,
  input  logic          b_hi,
  input  logic [HW-1:0] b_wdata,
  output logic          wr_hi,
  output logic          wr_lo,
  output logic [HW-1:0] wdata,
  output logic          rd_ack
);
  import mbox_pkg::*;

  localparam logic MY_BOX = (IDX == 0) ? BOX_TO_DSP : BOX_TO_CPU;

  logic a_hit, b_hit;
  logic a_w, b_w;
  logic any_w, sel_hi;

  always_comb begin
    a_hit  = a_en && (a_box == MY_BOX);
    b_hit  = b_en && (b_box == MY_BOX);
    a_w    = a_hit && a_wr;
    b_w    = b_hit && b_wr;
    any_w  = a_w || b_w;
    // Fixed priority: port A wins a same-cycle write collision.
    sel_hi = a_w ? a_hi : b_hi;
    wdata  = a_w ? a_wdata : b_wdata;
    wr_hi  = any_w && (sel_hi == HALF_HI);
    wr_lo  = any_w && (sel_hi == HALF_LO);
    rd_ack = (a_hit && !a_wr && (a_hi == HALF_LO)) ||
             (b_hit && !b_wr && (b_hi == HALF_LO));
  end

endmodule

// File: rtl/mbox_reg.sv
// One mailbox word with the pending flag in its top bit.
module mbox_reg #(
  parameter int HW = 16,
  localparam int W = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [HW-1:0] wdata,
  input  logic          rd_ack,
  output logic [W-1:0]  word
);

  logic [W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (wr_hi) begin
      // Upper half replaced; the flag is dropped so a partial message is not pending.
      word_q <= {1'b0, wdata[HW-2:0], word_q[HW-1:0]};
    end else if (wr_lo) begin
      // Lower half replaced; the flag commits the message.
      word_q <= {1'b1, word_q[W-2:HW], wdata};
    end else if (rd_ack) begin
      word_q[W-1] <= 1'b0;
    end
  end

  assign word = word_q;

endmodule

// File: rtl/mbox_irq.sv
// Interrupt-request register: bit 0 raises a host pulse, other non-zero values warn.
module mbox_irq #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_wr,
  input  logic [HW-1:0] irq_wdata,
  output logic          host_irq,
  output logic          irq_warn
);

  logic fire_d, warn_d;
  logic fire_q, warn_q;

  always_comb begin
    fire_d = irq_wr && irq_wdata[0];
    warn_d = irq_wr && !irq_wdata[0] && (|irq_wdata[HW-1:1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q <= 1'b0;
      warn_q <= 1'b0;
    end else begin
      fire_q <= fire_d;
      warn_q <= warn_d;
    end
  end

  assign host_irq = fire_q;
  assign irq_warn = warn_q;

endmodule

// File: rtl/mbox_pair_top.sv
module mbox_pair_top #(
  parameter int HW = 16,
  localparam int W = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic          a_wr,
  input  logic          a_box,
  input  logic          a_hi,
  input  logic [HW-1:0] a_wdata,
  output logic [HW-1:0] a_rdata,
  input  logic          b_en,
  input  logic          b_wr,
  input  logic          b_box,
  input  logic          b_hi,
  input  logic [HW-1:0] b_wdata,
  output logic [HW-1:0] b_rdata,
  input  logic          irq_wr,
  input  logic [HW-1:0] irq_wdata,
  output logic          host_irq,
  output logic          irq_warn,
  output logic          pend_to_dsp,
  output logic          pend_to_cpu,
  output logic [W-1:0]  peek_to_dsp,
  output logic [W-1:0]  peek_to_cpu
);
  import mbox_pkg::*;

  logic [W-1:0] box_word [NBOX];

  for (genvar g = 0; g < NBOX; g++) begin : g_box
    logic          wr_hi, wr_lo, rd_ack;
    logic [HW-1:0] wdata;

    mbox_arb #(.HW(HW), .IDX(g)) u_arb (
      .a_en    (a_en),
      .a_wr    (a_wr),
      .a_box   (a_box),
      .a_hi    (a_hi),
      .a_wdata (a_wdata),
      .b_en    (b_en),
      .b_wr    (b_wr),
      .b_box   (b_box),
      .b_hi    (b_hi),
      .b_wdata (b_wdata),
      .wr_hi   (wr_hi),
      .wr_lo   (wr_lo),
      .wdata   (wdata),
      .rd_ack  (rd_ack)
    );

    mbox_reg #(.HW(HW)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hi  (wr_hi),
      .wr_lo  (wr_lo),
      .wdata  (wdata),
      .rd_ack (rd_ack),
      .word   (box_word[g])
    );
  end

  mbox_irq #(.HW(HW)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_wr    (irq_wr),
    .irq_wdata (irq_wdata),
    .host_irq  (host_irq),
    .irq_warn  (irq_warn)
  );

  logic [W-1:0] a_sel_word, b_sel_word;

  always_comb begin
    a_sel_word = box_word[a_box];
    b_sel_word = box_word[b_box];
    a_rdata    = (a_hi == HALF_HI) ? a_sel_word[W-1:HW] : a_sel_word[HW-1:0];
    b_rdata    = (b_hi == HALF_HI) ? b_sel_word[W-1:HW] : b_sel_word[HW-1:0];
  end

  assign peek_to_dsp = box_word[BOX_TO_DSP];
  assign peek_to_cpu = box_word[BOX_TO_CPU];
  assign pend_to_dsp = box_word[BOX_TO_DSP][W-1];
  assign pend_to_cpu = box_word[BOX_TO_CPU][W-1];

endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk #(
  parameter int HW = 16,
  localparam int W = 2 * HW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_en,
  input logic          a_wr,
  input logic          a_box,
  input logic          a_hi,
  input logic [HW-1:0] a_wdata,
  input logic          b_en,
  input logic          b_wr,
  input logic          b_box,
  input logic          b_hi,
  input logic          irq_wr,
  input logic [HW-1:0] irq_wdata,
  input logic          host_irq,
  input logic          irq_warn,
  input logic          pend_to_dsp,
  input logic          pend_to_cpu,
  input logic [W-1:0]  peek_to_dsp
);

  logic a_wd, b_wd, a_rlo_d, b_rlo_d;
  logic a_wc, b_wc, a_rlo_c;

  always_comb begin
    a_wd    = a_en && a_wr && !a_box;
    b_wd    = b_en && b_wr && !b_box;
    a_rlo_d = a_en && !a_wr && !a_hi && !a_box;
    b_rlo_d = b_en && !b_wr && !b_hi && !b_box;
    a_wc    = a_en && a_wr && a_box;
    b_wc    = b_en && b_wr && b_box;
    a_rlo_c = a_en && !a_wr && !a_hi && a_box;
  end

  AST_HI_WRITE_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    a_wd && a_hi |=> !pend_to_dsp); // R2

  AST_LO_WRITE_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    a_wd && !a_hi |=> pend_to_dsp); // R3

  AST_LO_READ_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rlo_d || b_rlo_d) && !a_wd && !b_wd |=> !pend_to_dsp); // R4

  AST_QUIET_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !a_wd && !b_wd && !a_rlo_d && !b_rlo_d |=> $stable(peek_to_dsp)); // R5

  AST_WRITE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    b_wc && !b_hi && a_rlo_c |=> pend_to_cpu); // R7

  AST_PORT_A_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    a_wd && b_wd && !a_hi |=> peek_to_dsp[HW-1:0] == $past(a_wdata)); // R8

  AST_IRQ_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wr && irq_wdata[0] |=> host_irq && !irq_warn); // R9

  AST_IRQ_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_wr |=> !host_irq && !irq_warn); // R10

  AST_ZERO_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wr && (irq_wdata == '0) |=> !host_irq && !irq_warn); // R10

  AST_WARN_NOT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wr && !irq_wdata[0] && (irq_wdata != '0) |=> irq_warn && !host_irq); // R11

endmodule

bind mbox_pair_top mbox_pair_chk #(.HW(HW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .a_en        (a_en),
  .a_wr        (a_wr),
  .a_box       (a_box),
  .a_hi        (a_hi),
  .a_wdata     (a_wdata),
  .b_en        (b_en),
  .b_wr        (b_wr),
  .b_box       (b_box),
  .b_hi        (b_hi),
  .irq_wr      (irq_wr),
  .irq_wdata   (irq_wdata),
  .host_irq    (host_irq),
  .irq_warn    (irq_warn),
  .pend_to_dsp (pend_to_dsp),
  .pend_to_cpu (pend_to_cpu),
  .peek_to_dsp (peek_to_dsp)
);

// File: tb/mbox_pair_top_test.sv
module mbox_pair_top_test;
  localparam int HW = 16;
  localparam int W  = 2 * HW;

  localparam int S_RA   = 0;
  localparam int S_RB   = 1;
  localparam int S_PD   = 2;
  localparam int S_PC   = 3;
  localparam int S_PEND = 4;
  localparam int S_IRQ  = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          a_en = 0, a_wr = 0, a_box = 0, a_hi = 0;
  logic [HW-1:0] a_wdata = '0;
  logic          b_en = 0, b_wr = 0, b_box = 0, b_hi = 0;
  logic [HW-1:0] b_wdata = '0;
  logic          irq_wr = 0;
  logic [HW-1:0] irq_wdata = '0;
  logic [HW-1:0] a_rdata, b_rdata;
  logic          host_irq, irq_warn, pend_to_dsp, pend_to_cpu;
  logic [W-1:0]  peek_to_dsp, peek_to_cpu;

  mbox_pair_top #(.HW(HW)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_wr(a_wr), .a_box(a_box), .a_hi(a_hi),
    .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_wr(b_wr), .b_box(b_box), .b_hi(b_hi),
    .b_wdata(b_wdata), .b_rdata(b_rdata),
    .irq_wr(irq_wr), .irq_wdata(irq_wdata),
    .host_irq(host_irq), .irq_warn(irq_warn),
    .pend_to_dsp(pend_to_dsp), .pend_to_cpu(pend_to_cpu),
    .peek_to_dsp(peek_to_dsp), .peek_to_cpu(peek_to_cpu)
  );

  int cyc_cnt = 0;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sbq[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic logic [31:0] observe(int sel);
    case (sel)
      S_RA:    return {16'h0, a_rdata};
      S_RB:    return {16'h0, b_rdata};
      S_PD:    return peek_to_dsp;
      S_PC:    return peek_to_cpu;
      S_PEND:  return {30'h0, pend_to_cpu, pend_to_dsp};
      default: return {30'h0, irq_warn, host_irq};
    endcase
  endfunction

  // delay 0: value before the coming edge; delay 1: value after it.
  task automatic expect_at(int delay, int sel, logic [31:0] v, string req);
    item_t it;
    it.due = cyc_cnt + delay;
    it.sel = sel;
    it.exp = v;
    it.req = req;
    sbq.push_back(it);
  endtask

  // Monitor: pops due items one ns before each rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (sbq.size() > 0 && sbq[0].due <= cyc_cnt) begin
        item_t it;
        logic [31:0] got;
        it = sbq.pop_front();
        got = observe(it.sel);
        n_run++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    a_en = 0; a_wr = 0; a_box = 0; a_hi = 0; a_wdata = '0;
    b_en = 0; b_wr = 0; b_box = 0; b_hi = 0; b_wdata = '0;
    irq_wr = 0; irq_wdata = '0;
  endtask

  task automatic op_a(logic wr, logic box, logic hi, logic [HW-1:0] d);
    a_en = 1; a_wr = wr; a_box = box; a_hi = hi; a_wdata = d;
  endtask

  task automatic op_b(logic wr, logic box, logic hi, logic [HW-1:0] d);
    b_en = 1; b_wr = wr; b_box = box; b_hi = hi; b_wdata = d;
  endtask

  task automatic op_irq(logic [HW-1:0] d);
    irq_wr = 1; irq_wdata = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    expect_at(0, S_PD, 32'h0, "R1");
    expect_at(0, S_PC, 32'h0, "R1");
    expect_at(0, S_PEND, 32'h0, "R1");
    expect_at(0, S_IRQ, 32'h0, "R1");

    tick(); op_a(1, 0, 1, 16'hFFFF);
    expect_at(1, S_PD, 32'h7FFF0000, "R2");
    expect_at(1, S_PEND, 32'h0, "R2");

    tick(); op_a(1, 0, 0, 16'h1234);
    expect_at(1, S_PD, 32'hFFFF1234, "R3");
    expect_at(1, S_PEND, 32'h1, "R6");

    tick(); op_b(0, 0, 1, '0);
    expect_at(0, S_RB, 32'hFFFF, "R5");
    expect_at(1, S_PD, 32'hFFFF1234, "R5");

    tick(); op_b(0, 0, 0, '0);
    expect_at(0, S_RB, 32'h1234, "R4");
    expect_at(1, S_PD, 32'h7FFF1234, "R4");
    expect_at(1, S_PEND, 32'h0, "R4");

    tick(); op_b(1, 1, 1, 16'hABCD);
    expect_at(1, S_PC, 32'h2BCD0000, "R2");

    tick(); op_b(1, 1, 0, 16'h5555);
    expect_at(1, S_PC, 32'hABCD5555, "R3");
    expect_at(1, S_PEND, 32'h2, "R6");

    tick(); op_a(0, 1, 1, '0);
    expect_at(0, S_RA, 32'hABCD, "R5");

    tick(); op_a(0, 1, 0, '0); op_b(1, 1, 0, 16'h6666);
    expect_at(0, S_RA, 32'h5555, "R7");
    expect_at(1, S_PC, 32'hABCD6666, "R7");
    expect_at(1, S_PEND, 32'h2, "R7");

    tick(); op_a(1, 0, 0, 16'h1111); op_b(1, 0, 0, 16'h2222);
    expect_at(1, S_PD, 32'hFFFF1111, "R8");

    tick(); op_a(1, 1, 1, 16'h0001); op_b(1, 0, 1, 16'h0002);
    expect_at(1, S_PC, 32'h00016666, "R12");
    expect_at(1, S_PD, 32'h00021111, "R12");
    expect_at(1, S_PEND, 32'h0, "R12");

    tick(); op_a(1, 0, 0, 16'hBEEF); op_b(1, 0, 1, 16'h7777);
    expect_at(1, S_PD, 32'h8002BEEF, "R8");

    tick(); op_irq(16'h0001);
    expect_at(1, S_IRQ, 32'h1, "R9");

    tick();
    expect_at(1, S_IRQ, 32'h0, "R9");

    tick(); op_irq(16'h0000);
    expect_at(1, S_IRQ, 32'h0, "R10");

    tick(); op_irq(16'h0002);
    expect_at(1, S_IRQ, 32'h2, "R11");

    tick(); op_irq(16'h8000);
    expect_at(1, S_IRQ, 32'h2, "R11");

    tick(); op_irq(16'hFFFF);
    expect_at(1, S_IRQ, 32'h1, "R9");

    tick();
    expect_at(1, S_IRQ, 32'h0, "R9");

    repeat (3) tick();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule